// File: doc/BRIEF.md
# Serial EEPROM Access Sequencer

This block drives a 512-byte serial EEPROM over a four-wire SPI link and serves byte-level read and write requests from a host. The host posts one command: an operation, a start address and a byte count. The block then runs every bus transaction that the command needs and ends with a one-cycle completion pulse and an error code. Write bytes come in on a ready/valid stream, and read bytes go out on a second ready/valid stream that the host may stall.

Each read or write is preceded by a status poll that waits while the device reports a write cycle in progress. The poll count has a bound, so a stuck device ends the request with a timeout. Writes are cut into chunks that never cross a 16-byte page. Each chunk is preceded by its own write-enable transaction. A third operation tests whether the device is present. It sets the write-enable latch, reads it back as set, clears it, and reads it back as clear.

Top module: `sprom_access`

## Requirements
- R1: A read or write whose byte count is 0 ends with code 1 (argument error). One whose start address is 512 or more ends with code 2 (address error). Operation encoding 3 ends with code 1. None of these lowers `cs_n`.
- R2: SPI mode 0, MSB first. `sck` idles low, each `sck` high phase lasts 8 clocks (clock divided by 16), and `sck` never goes high while `cs_n` is high.
- R3: Every read and write begins with a status transaction: byte 0x05, then a dummy byte. The byte returned in the second slot is the status, with bit 0 = busy and bit 1 = write-enable latch. While busy, the poll repeats. If the busy bit is still set after RETRY+1 status reads, the request ends with code 3 (timeout) and no data transaction is issued.
- R4: Operation 0 (read) sends header byte 0x03 with address bit 8 at bit 3, then the low 8 address bits, then clocks in the requested byte count, all under one `cs_n` low. Bytes leave on `rd_data` in address order. `rd_valid` and `rd_data` hold until `rd_ready` is high.
- R5: Operation 1 (write) is split into chunks. Each chunk length is the smaller of the bytes left and 16 minus (address mod 16), so no chunk crosses a 16-byte page.
- R6: Each write chunk is preceded by a status poll and by a one-byte 0x06 transaction. The chunk's header is 0x02 with address bit 8 at bit 4, then the low address byte, then the chunk's data, taken from the write stream only while `cs_n` is low.
- R7: Operation 2 (presence check) sends 0x06, reads status and needs bit 1 = 1, then sends 0x04, reads status and needs bit 1 = 0. Success gives code 0 with `present` = 1. Any mismatch gives code 4 with `present` = 0.
- R8: `cs_n` stays high for at least 16 clocks between any two transactions.
- R9: `cmd_ready` is high only while the block is idle, and never while `cs_n` is low. `done` is a one-cycle pulse, and `err` and `present` are valid from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_op | input | 2 | 0 read, 1 write, 2 presence check |
| cmd_addr | input | 16 | Start byte address |
| cmd_len | input | 10 | Byte count |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Write stream byte taken |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte present |
| rd_ready | input | 1 | Host accepts read byte |
| done | output | 1 | Request finished (pulse) |
| err | output | 3 | 0 ok, 1 argument, 2 address, 3 timeout, 4 absent |
| present | output | 1 | Result of last presence check |
| sck | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |

## Verification
The busy-poll limit check and the decision to go on with the access land on the same status reading, when the device stops being busy on exactly the last allowed poll. The bench's device model is set busy for exactly RETRY readings, where the request must proceed, and then for RETRY+1 readings, where it must time out without any data transaction. A second overlap happens when a read byte completes while the host still holds the previous byte. The host stalls `rd_ready` in a pattern, and every delivered byte is compared in order with the bench's shadow memory.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_PROBE = 2'd2} op_e;
  typedef enum logic [2:0] {E_OK = 3'd0, E_ARG = 3'd1, E_ADDR = 3'd2,
                            E_TIMEOUT = 3'd3, E_ABSENT = 3'd4} err_e;
  typedef enum logic [3:0] {ST_IDLE, ST_RDSR0, ST_RDSR1, ST_LATCH, ST_HDR0,
                            ST_HDR1, ST_DATA, ST_GAP, ST_DONE} st_e;

  // header opcode: the ninth address bit rides at bit 3 (read) or bit 4 (write)
  function automatic logic [7:0] head_byte(input logic wr, input logic a8);
    logic [7:0] r;
    r = wr ? OPC_WRITE : OPC_READ;
    if (wr) r[4] = a8;
    else    r[3] = a8;
    return r;
  endfunction

  // bytes that fit before the next page boundary, capped by what is left
  function automatic int chunk_of(input int a, input int left, input int page);
    int room;
    room = page - (a % page);
    return (left < room) ? left : room;
  endfunction
endpackage

// File: rtl/sprom_shift.sv
module sprom_shift #(
  parameter int DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       done,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic          act, smp, done_q;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; smp <= 1'b0; done_q <= 1'b0;
      cnt <= '0; bitn <= '0; sh <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !act) begin
        act <= 1'b1; sh <= tx; cnt <= '0; bitn <= '0;
      end else if (act) begin
        cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
        if (cnt == CW'(HALF)) smp <= miso;
        if (cnt == CW'(DIV - 1)) begin
          sh   <= {sh[6:0], smp};
          bitn <= bitn + 1'b1;
          if (bitn == 3'd7) begin
            act    <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sck  = act && (cnt >= CW'(HALF));
  assign mosi = sh[7];
  assign rx   = sh;
  assign done = done_q;
endmodule

// File: rtl/sprom_gap.sv
module sprom_gap #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic expired
);
  localparam int CW = $clog2(DIV);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!hold) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign expired = hold && (cnt == CW'(DIV - 1));
endmodule

// File: rtl/sprom_access.sv
module sprom_access
  import sprom_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int PAGE   = 16,
  parameter int DIV    = 16,
  parameter int RETRY  = 250,
  parameter int LEN_W  = 10,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              done,
  output logic [2:0]        err,
  output logic              present,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int AW = $clog2(DEPTH);
  localparam int RW = $clog2(RETRY + 1);

  st_e              st, gap_nx;
  op_e              op_q;
  err_e             code_q, err_q;
  logic [AW-1:0]    addr_q;
  logic [LEN_W-1:0] left_q, ccnt_q;
  logic [RW-1:0]    polls_q;
  logic             stage_q, pres_q, issued, rdv_q, done_q, present_q;
  logic [7:0]       rdd_q, latch_op, tx_byte, sh_rx;
  logic             sh_done, gap_exp;

  // named events
  logic in_frame, byte_go, stat_done, busy_seen, poll_limit, chunk_last;
  assign in_frame   = st inside {ST_RDSR0, ST_RDSR1, ST_LATCH, ST_HDR0, ST_HDR1, ST_DATA};
  assign byte_go    = in_frame && !issued &&
                      ((st != ST_DATA) || ((op_q == OP_WRITE) ? wr_valid : !rdv_q));
  assign stat_done  = (st == ST_RDSR1) && sh_done;
  assign busy_seen  = stat_done && sh_rx[0];
  assign poll_limit = (polls_q == RW'(RETRY));
  assign chunk_last = (st == ST_DATA) && sh_done && (ccnt_q == LEN_W'(1));

  always_comb begin
    case (st)
      ST_RDSR0: tx_byte = OPC_RDSR;
      ST_LATCH: tx_byte = latch_op;
      ST_HDR0:  tx_byte = head_byte(op_q == OP_WRITE, addr_q[AW-1]);
      ST_HDR1:  tx_byte = addr_q[7:0];
      ST_DATA:  tx_byte = wr_data;
      default:  tx_byte = 8'h00;
    endcase
  end

  sprom_shift #(.DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(byte_go), .tx(tx_byte), .miso(miso),
    .done(sh_done), .rx(sh_rx), .sck(sck), .mosi(mosi)
  );

  sprom_gap #(.DIV(DIV)) u_gap (
    .clk(clk), .rst_n(rst_n), .hold(st == ST_GAP), .expired(gap_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; gap_nx <= ST_IDLE; op_q <= OP_READ;
      code_q <= E_OK; err_q <= E_OK; addr_q <= '0; left_q <= '0; ccnt_q <= '0;
      polls_q <= '0; stage_q <= 1'b0; pres_q <= 1'b0; issued <= 1'b0;
      rdv_q <= 1'b0; rdd_q <= '0; done_q <= 1'b0; present_q <= 1'b0;
      latch_op <= OPC_WREN;
    end else begin
      done_q <= 1'b0;
      if (rdv_q && rd_ready) rdv_q <= 1'b0;
      if (byte_go) issued <= 1'b1;
      if (sh_done) issued <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          op_q <= op_e'(cmd_op);
          addr_q <= cmd_addr[AW-1:0];
          left_q <= cmd_len;
          polls_q <= '0; stage_q <= 1'b0; pres_q <= 1'b0; code_q <= E_OK;
          if (cmd_op == OP_PROBE) begin
            latch_op <= OPC_WREN; st <= ST_LATCH;
          end else if (cmd_op == 2'd3 || cmd_len == '0) begin
            code_q <= E_ARG; st <= ST_DONE;
          end else if (cmd_addr >= ADDR_W'(DEPTH)) begin
            code_q <= E_ADDR; st <= ST_DONE;
          end else st <= ST_RDSR0;
        end
        ST_RDSR0: if (sh_done) st <= ST_RDSR1;
        ST_RDSR1: if (stat_done) begin
          st <= ST_GAP;
          if (op_q == OP_PROBE) begin
            if (sh_rx[1] == stage_q) begin
              code_q <= E_ABSENT; gap_nx <= ST_DONE;
            end else if (!stage_q) begin
              stage_q <= 1'b1; latch_op <= OPC_WRDI; gap_nx <= ST_LATCH;
            end else begin
              pres_q <= 1'b1; gap_nx <= ST_DONE;
            end
          end else if (busy_seen) begin
            if (poll_limit) begin
              code_q <= E_TIMEOUT; gap_nx <= ST_DONE;
            end else begin
              polls_q <= polls_q + 1'b1; gap_nx <= ST_RDSR0;
            end
          end else begin
            polls_q <= '0;
            if (op_q == OP_READ) begin
              ccnt_q <= left_q; gap_nx <= ST_HDR0;
            end else begin
              latch_op <= OPC_WREN; gap_nx <= ST_LATCH;
            end
          end
        end
        ST_LATCH: if (sh_done) begin
          st <= ST_GAP;
          if (op_q == OP_PROBE) gap_nx <= ST_RDSR0;
          else begin
            ccnt_q <= LEN_W'(chunk_of(int'(addr_q), int'(left_q), PAGE));
            gap_nx <= ST_HDR0;
          end
        end
        ST_HDR0: if (sh_done) st <= ST_HDR1;
        ST_HDR1: if (sh_done) st <= ST_DATA;
        ST_DATA: if (sh_done) begin
          ccnt_q <= ccnt_q - 1'b1;
          addr_q <= addr_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (op_q == OP_READ) begin
            rdd_q <= sh_rx; rdv_q <= 1'b1;
          end
          if (chunk_last) begin
            st <= ST_GAP;
            gap_nx <= (left_q == LEN_W'(1)) ? ST_DONE : ST_RDSR0;
          end
        end
        ST_GAP: if (gap_exp) st <= gap_nx;
        ST_DONE: if (!rdv_q) begin
          done_q <= 1'b1; err_q <= code_q; present_q <= pres_q; st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == ST_IDLE);
  assign wr_ready  = (st == ST_DATA) && (op_q == OP_WRITE) && !issued;
  assign cs_n      = !in_frame;
  assign rd_data   = rdd_q;
  assign rd_valid  = rdv_q;
  assign done      = done_q;
  assign err       = err_q;
  assign present   = present_q;
endmodule

// File: rtl/sprom_chk.sv
module sprom_chk #(
  parameter int DIV = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       done,
  input logic       cmd_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       wr_ready
);
  localparam int HW = $clog2(DIV) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hi_cnt <= HW'(DIV);
    else if (!cs_n)         hi_cnt <= '0;
    else if (hi_cnt < HW'(DIV)) hi_cnt <= hi_cnt + 1'b1;
  end

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= HW'(DIV)));
  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> cs_n);
  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R6
  wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !cs_n);
endmodule

bind sprom_access sprom_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .done(done),
  .cmd_ready(cmd_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .wr_ready(wr_ready)
);

// File: tb/sim_sprom_access.sv
module sim_sprom_access;
  localparam int RET = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, wr_valid = 0, wr_ready, rd_valid, rd_ready = 0;
  logic done, present, sck, cs_n, mosi, miso;
  logic [1:0] cmd_op = 0;
  logic [15:0] cmd_addr = 0;
  logic [9:0] cmd_len = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [2:0] err;

  sprom_access #(.RETRY(RET)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .done(done), .err(err), .present(present), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int checks = 0, fails = 0;
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural device ----------------
  logic [7:0] mem [512];
  logic [7:0] ref_mem [512];
  logic wel = 0;
  int busy_left = 0, busy_after_wr = 2;
  bit stick_busy = 0, ign_wrdi = 0;
  logic [7:0] q [$];
  logic [7:0] in_sh = 0, out_sh = 0;
  int bitc = 0;
  int polls = 0, reads_seen = 0, page_err = 0, bad_write = 0, cs_falls = 0;
  int last_rd_op = -1, last_wr_op = -1;
  int chunks [$];
  assign miso = out_sh[7];

  function automatic logic [7:0] next_out();
    logic [8:0] ra;
    if (q.size() == 1 && q[0] == 8'h05)
      return {6'b0, wel, (stick_busy || busy_left > 0)};
    if (q.size() >= 2 && (q[0] & 8'hF7) == 8'h03) begin
      ra = {q[0][3], q[1]} + 9'(q.size() - 2);
      return mem[ra];
    end
    return 8'h00;
  endfunction

  always @(negedge cs_n) begin q.delete(); bitc = 0; out_sh = 8'h00; cs_falls++; end
  always @(posedge sck) if (!cs_n) begin
    in_sh = {in_sh[6:0], mosi}; bitc++;
    if (bitc == 8) begin bitc = 0; q.push_back(in_sh); end
  end
  always @(negedge sck) if (!cs_n) begin
    if (bitc == 0) out_sh = next_out();
    else out_sh = out_sh << 1;
  end
  always @(posedge cs_n) begin
    logic [8:0] a;
    int n;
    if (q.size() == 1 && q[0] == 8'h06) wel = 1;
    if (q.size() == 1 && q[0] == 8'h04 && !ign_wrdi) wel = 0;
    if (q.size() >= 2 && q[0] == 8'h05) begin
      polls++; if (busy_left > 0) busy_left--;
    end
    if (q.size() >= 2 && (q[0] & 8'hF7) == 8'h03) begin reads_seen++; last_rd_op = q[0]; end
    if (q.size() >= 3 && (q[0] & 8'hEF) == 8'h02) begin
      last_wr_op = q[0];
      if (!wel || stick_busy || busy_left > 0) bad_write++;
      else begin
        a = {q[0][4], q[1]}; n = q.size() - 2;
        if ((int'(a) % 16) + n > 16) page_err++;
        chunks.push_back(n);
        for (int i = 0; i < n; i++) mem[a + 9'(i)] = q[i + 2];
        wel = 0; busy_left = busy_after_wr;
      end
    end
  end

  // ---------------- per-clock monitors ----------------
  int hi = 99, hpulse = 0;
  always @(negedge clk) if (rst_n) begin
    if (cs_n) hi++;
    else begin
      if (hi > 0 && hi < 99) chk("R8 cs_n high gap", (hi >= 16) ? 1 : 0, 1);
      hi = 0;
    end
    if (sck) hpulse++;
    else if (hpulse > 0) begin chk("R2 sck high phase", hpulse, 8); hpulse = 0; end
    if (cs_n && sck) chk("R2 sck while deselected", 1, 0);
    if (cmd_ready && !cs_n) chk("R9 ready while framed", 1, 0);
  end

  // ---------------- host driver ----------------
  task automatic run(input int op, input int addr, input int len, input logic [7:0] wq_in[$],
                     output logic [7:0] got[$], output int e, output int p, input bit slow);
    int cyc = 0;
    logic [7:0] wq[$];
    wq = wq_in; got = {};
    @(negedge clk);
    chk("R9 ready before command", int'(cmd_ready), 1);
    cmd_valid = 1; cmd_op = 2'(op); cmd_addr = 16'(addr); cmd_len = 10'(len);
    @(negedge clk);
    cmd_valid = 0;
    forever begin
      wr_valid = (wq.size() > 0);
      wr_data = (wq.size() > 0) ? wq[0] : 8'h00;
      rd_ready = slow ? (cyc % 3 == 0) : 1'b1;
      #1;
      if (wr_valid && wr_ready) void'(wq.pop_front());
      if (rd_valid && rd_ready) got.push_back(rd_data);
      if (done) begin e = int'(err); p = int'(present); break; end
      cyc++;
      if (cyc > 60000) begin chk("watchdog request", 0, 1); e = -1; p = -1; break; end
      @(negedge clk);
    end
    wr_valid = 0; rd_ready = 0;
    @(negedge clk);
    chk("R9 done is one cycle", int'(done), 0);
  endtask

  task automatic read_cmp(input string req, input int addr, input int len, input bit slow);
    logic [7:0] none[$], got[$];
    int e, p;
    none = {};
    run(0, addr, len, none, got, e, p, slow);
    chk({req, " read code"}, e, 0);
    chk({req, " read count"}, got.size(), len);
    for (int i = 0; i < len && i < got.size(); i++)
      if (got[i] !== ref_mem[(addr + i) % 512]) chk({req, " read byte"}, got[i], ref_mem[(addr + i) % 512]);
    checks++;
  endtask

  task automatic write_exp(input int addr, input int len, input int seed, input string req);
    logic [7:0] wq[$], got[$];
    int e, p, a, left, room, n0;
    int exp_chunks[$];
    wq = {};
    for (int i = 0; i < len; i++) begin
      wq.push_back(8'(seed + 7 * i));
      ref_mem[(addr + i) % 512] = 8'(seed + 7 * i);
    end
    a = addr; left = len;
    while (left > 0) begin
      room = 16 - (a & 15);
      exp_chunks.push_back(left < room ? left : room);
      a += (left < room ? left : room); left -= (left < room ? left : room);
    end
    n0 = chunks.size();
    run(1, addr, len, wq, got, e, p, 0);
    chk({req, " R6 write code"}, e, 0);
    chk({req, " R5 chunk count"}, chunks.size() - n0, exp_chunks.size());
    for (int i = 0; i < exp_chunks.size() && n0 + i < chunks.size(); i++)
      chk({req, " R5 chunk length"}, chunks[n0 + i], exp_chunks[i]);
  endtask

  int e, p, base, n0;
  logic [7:0] none[$], got[$];

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i ^ 8'h5A); ref_mem[i] = 8'(i ^ 8'h5A);
    end
    none = {};
    repeat (4) @(negedge clk);
    chk("R9 reset cs_n", int'(cs_n), 1);
    chk("R2 reset sck", int'(sck), 0);
    chk("R9 reset ready", int'(cmd_ready), 1);
    chk("R9 reset done", int'(done), 0);
    rst_n = 1;
    repeat (20) @(negedge clk);

    // R1 rejections
    base = cs_falls;
    run(0, 5, 0, none, got, e, p, 0);       chk("R1 zero length", e, 1);
    run(1, 512, 4, none, got, e, p, 0);     chk("R1 address 512", e, 2);
    run(3, 0, 1, none, got, e, p, 0);       chk("R1 bad op", e, 1);
    chk("R1 no bus activity", cs_falls - base, 0);

    // R3 R4 read with host stalls
    base = polls;
    read_cmp("R4 top page", 508, 4, 1);
    chk("R4 header with a8", last_rd_op, 8'h0B);
    chk("R3 single poll", polls - base, 1);

    // R5 R6 writes
    write_exp(266, 20, 8'h31, "upper");
    chk("R6 header with a8", last_wr_op, 8'h12);
    chk("R6 enable before each chunk", bad_write, 0);
    chk("R5 no page crossing", page_err, 0);
    base = polls;
    read_cmp("R4 readback upper", 264, 24, 1);
    chk("R3 waited out busy", polls - base, busy_after_wr + 1);
    write_exp(14, 3, 8'hC4, "lower");
    chk("R6 header low half", last_wr_op, 8'h02);
    read_cmp("R4 readback lower", 12, 8, 0);

    // R3 boundary: busy for exactly RETRY readings passes, RETRY+1 times out
    busy_left = RET;
    read_cmp("R3 last poll clears", 40, 2, 0);
    busy_left = RET + 1; base = reads_seen; n0 = polls;
    run(0, 40, 2, none, got, e, p, 0);
    chk("R3 timeout code", e, 3);
    chk("R3 no data after timeout", reads_seen - base, 0);
    chk("R3 poll count at timeout", polls - n0, RET + 1);
    chk("R3 no bytes delivered", got.size(), 0);

    // R3 write against stuck device is dropped
    stick_busy = 1; n0 = chunks.size(); base = bad_write;
    begin
      logic [7:0] wq[$];
      wq = {8'hEE, 8'hEF};
      run(1, 100, 2, wq, got, e, p, 0);
    end
    chk("R3 write timeout code", e, 3);
    chk("R3 no write transaction", (chunks.size() - n0) + (bad_write - base), 0);
    stick_busy = 0;
    read_cmp("R3 memory untouched", 100, 2, 0);

    // R7 presence
    run(2, 0, 0, none, got, e, p, 0);
    chk("R7 probe code", e, 0); chk("R7 probe present", p, 1);
    chk("R7 latch left clear", int'(wel), 0);
    ign_wrdi = 1;
    run(2, 0, 0, none, got, e, p, 0);
    chk("R7 stuck latch code", e, 4); chk("R7 stuck latch absent", p, 0);
    ign_wrdi = 0;

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule